// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs one external memory cycle at a time on a multiplexed 8-bit bus. A requester hands it a 16-bit address, a strobe selection (data read, data write or code fetch), write data and a programmed wait-state count. The sequencer raises the address latch enable, places the address on the two byte ports, then asserts the selected strobe for a stretched data phase. It returns the captured read byte with a one-clock completion pulse.

The data phase is lengthened by three merged sources: the programmed count, an asynchronous wait input and an optional synchronous real-time wait input. Two multiplexing schemes are supported. In the first, the low port shares address and data. In the second, the high port does. The address latch pulse can be long or short. A wait clock at half the block clock can be driven out for external ready logic. One block clock equals one oscillator period.

The request side is a valid/ready stream. `req_ready` is high only while the sequencer is idle. A requester keeps `req_valid` and all request fields stable until it sees `req_ready` high at a clock edge, and the transfer happens at that edge. No new request is taken until the completion pulse has passed.

Top module: `ebus_seq`

## Requirements
- R1: After reset, `req_ready` is 1. `ale`, `done`, `wclk`, `p0_oe` and `p2_oe` are 0, and `rd_n`, `wr_n` and `psen_n` are all 1.
- R2: After a request is accepted, `ale` is high for 3 consecutive clocks when `cfg_long_ale` was 1 at acceptance, and for 1 clock otherwise. While `ale` is high, `p0_out` carries address bits 7:0 and `p2_out` carries bits 15:8, with both enables at 1. No strobe is active while `ale` is high.
- R3: With `cfg_page` = 0, during the strobe phase `p2_out` keeps address bits 15:8 with `p2_oe` = 1. Port 0 is the data port.
- R4: With `cfg_page` = 1, during the strobe phase `p0_out` keeps address bits 7:0 with `p0_oe` = 1. Port 2 is the data port.
- R5: With no wait input active, the strobe stays low for exactly 2 + 2*`req_waits` clocks (`req_waits` from 0 to 3).
- R6: While the synchronized `await_n` is low, the strobe is held. `await_n` passes two synchronizing flops, so the strobe deasserts on the third clock edge after `await_n` rises, once the programmed count has run out.
- R7: When `cfg_rt_wait_en` = 1, a low `wait_n` holds the strobe, and the strobe deasserts at the first clock edge that samples `wait_n` high. When `cfg_rt_wait_en` = 0, `wait_n` has no effect on the strobe length.
- R8: When `cfg_wclk_en` = 1, `wclk` toggles on every clock, giving a square wave at half the clock rate. When `cfg_wclk_en` = 0, `wclk` is 0.
- R9: For reads and code fetches, `rdata` holds the data-port input (`p0_in` when not paged, `p2_in` when paged) sampled on the last clock of the strobe. `done` is high for exactly one clock, the first clock after the strobe deasserts.
- R10: For writes, the data port drives `req_wdata` with its enable at 1 during the strobe. For reads and code fetches, the data port enable is 0 during the strobe.
- R11: `req_ready` falls in the clock after a request is accepted and returns to 1 in the clock after `done`.
- R12: `req_strobe` encoding: 1 selects `wr_n`, 2 selects `psen_n`, and 0 or 3 select `rd_n`. Only the selected strobe goes low, and at most one strobe is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one oscillator period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_addr | input | 16 | Cycle address |
| req_strobe | input | 2 | Strobe select (see R12) |
| req_waits | input | 2 | Programmed wait states, 0 to 3 |
| req_wdata | input | 8 | Write data |
| cfg_long_ale | input | 1 | 1 selects a 3-clock address latch pulse |
| cfg_page | input | 1 | 1 moves data onto port 2 |
| cfg_rt_wait_en | input | 1 | Enables the synchronous wait input |
| cfg_wclk_en | input | 1 | Enables the wait clock output |
| await_n | input | 1 | Asynchronous wait, active low |
| wait_n | input | 1 | Synchronous real-time wait, active low |
| p0_in | input | 8 | Port 0 pin input |
| p2_in | input | 8 | Port 2 pin input |
| ale | output | 1 | Address latch enable |
| p0_out | output | 8 | Port 0 drive value |
| p0_oe | output | 1 | Port 0 drive enable |
| p2_out | output | 8 | Port 2 drive value |
| p2_oe | output | 1 | Port 2 drive enable |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| psen_n | output | 1 | Code fetch strobe, active low |
| wclk | output | 1 | Wait clock output |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured read byte |

## Verification
A wrong phase counter shows as an address latch or strobe width off by whole clocks, visible within the cycle it corrupts. A wrong state or mux selection shows up in the same clock as the wrong port carrying address instead of data, a stray enable, or a wrong strobe going low. A broken wait merge or synchronizer depth changes the strobe length by one or more clocks relative to the release of the wait pin. A capture-timing fault leaves a stale or wrong byte on `rdata` by the time `done` rises.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ALE  = 2'd1,
    ST_STB  = 2'd2,
    ST_DONE = 2'd3
  } bus_state_t;

  localparam logic [1:0] SEL_WRITE = 2'd1;
  localparam logic [1:0] SEL_CODE  = 2'd2;
endpackage

// File: rtl/ebus_sync2.sv
module ebus_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RESET_VAL;
      q_sync <= RESET_VAL;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/ebus_wait_merge.sv
module ebus_wait_merge (
  input  logic await_sync_n,
  input  logic rt_wait_n,
  input  logic rt_enable,
  output logic stall
);
  always_comb begin
    stall = ~await_sync_n | (rt_enable & ~rt_wait_n);
  end
endmodule

// File: rtl/ebus_wclk.sv
module ebus_wclk (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic wclk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wclk <= 1'b0;
    else if (enable)  wclk <= ~wclk;
    else              wclk <= 1'b0;
  end
endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
  import ebus_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WS_W      = 2,
  parameter int LONG_ALE  = 3,
  parameter int SHORT_ALE = 1,
  parameter int BASE_STB  = 2,
  parameter int WS_CLKS   = 2,
  localparam int ADDR_W   = 2 * DATA_W,
  localparam int MAX_STB  = BASE_STB + WS_CLKS * ((1 << WS_W) - 1),
  localparam int MAX_CNT  = (MAX_STB > LONG_ALE) ? MAX_STB : LONG_ALE,
  localparam int CNT_W    = $clog2(MAX_CNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_strobe,
  input  logic [WS_W-1:0]   req_waits,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              long_ale,
  input  logic              stall,
  output bus_state_t        state,
  output logic [ADDR_W-1:0] addr_q,
  output logic [1:0]        sel_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              capture
);
  logic [CNT_W-1:0] cnt;
  logic [WS_W-1:0]  waits_q;

  always_comb begin
    capture = (state == ST_STB) && (cnt == '0) && !stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      sel_q   <= '0;
      wdata_q <= '0;
      waits_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            sel_q   <= req_strobe;
            wdata_q <= req_wdata;
            waits_q <= req_waits;
            cnt     <= long_ale ? CNT_W'(LONG_ALE - 1) : CNT_W'(SHORT_ALE - 1);
            state   <= ST_ALE;
          end
        end
        ST_ALE: begin
          if (cnt == '0) begin
            cnt   <= CNT_W'(BASE_STB - 1) + CNT_W'(WS_CLKS) * CNT_W'(waits_q);
            state <= ST_STB;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STB: begin
          if (cnt != '0)   cnt   <= cnt - 1'b1;
          else if (!stall) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WS_W     = 2,
  localparam int ADDR_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_strobe,
  input  logic [WS_W-1:0]   req_waits,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cfg_long_ale,
  input  logic              cfg_page,
  input  logic              cfg_rt_wait_en,
  input  logic              cfg_wclk_en,
  input  logic              await_n,
  input  logic              wait_n,
  input  logic [DATA_W-1:0] p0_in,
  input  logic [DATA_W-1:0] p2_in,
  output logic              ale,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [DATA_W-1:0] p2_out,
  output logic              p2_oe,
  output logic              rd_n,
  output logic              wr_n,
  output logic              psen_n,
  output logic              wclk,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  bus_state_t        state;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        sel_q;
  logic [DATA_W-1:0] wdata_q;
  logic              capture;
  logic              await_s;
  logic              stall;
  logic              is_write;
  logic              is_code;
  logic              in_stb;
  logic [DATA_W-1:0] addr_lo;
  logic [DATA_W-1:0] addr_hi;

  ebus_sync2 #(.RESET_VAL(1'b1)) u_await_sync (
    .clk(clk), .rst_n(rst_n), .d_async(await_n), .q_sync(await_s)
  );

  ebus_wait_merge u_merge (
    .await_sync_n(await_s), .rt_wait_n(wait_n),
    .rt_enable(cfg_rt_wait_en), .stall(stall)
  );

  ebus_wclk u_wclk (
    .clk(clk), .rst_n(rst_n), .enable(cfg_wclk_en), .wclk(wclk)
  );

  ebus_ctrl #(.DATA_W(DATA_W), .WS_W(WS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_strobe(req_strobe), .req_waits(req_waits), .req_wdata(req_wdata),
    .long_ale(cfg_long_ale), .stall(stall), .state(state), .addr_q(addr_q),
    .sel_q(sel_q), .wdata_q(wdata_q), .capture(capture)
  );

  always_comb begin
    addr_lo   = addr_q[DATA_W-1:0];
    addr_hi   = addr_q[ADDR_W-1:DATA_W];
    is_write  = (sel_q == SEL_WRITE);
    is_code   = (sel_q == SEL_CODE);
    in_stb    = (state == ST_STB);
    req_ready = (state == ST_IDLE);
    ale       = (state == ST_ALE);
    done      = (state == ST_DONE);
    rd_n      = ~(in_stb & ~is_write & ~is_code);
    wr_n      = ~(in_stb & is_write);
    psen_n    = ~(in_stb & is_code);
  end

  always_comb begin
    p0_out = '0;
    p2_out = '0;
    p0_oe  = 1'b0;
    p2_oe  = 1'b0;
    case (state)
      ST_ALE: begin
        p0_out = addr_lo;
        p2_out = addr_hi;
        p0_oe  = 1'b1;
        p2_oe  = 1'b1;
      end
      ST_STB: begin
        if (cfg_page) begin
          p0_out = addr_lo;
          p0_oe  = 1'b1;
          p2_out = wdata_q;
          p2_oe  = is_write;
        end else begin
          p2_out = addr_hi;
          p2_oe  = 1'b1;
          p0_out = wdata_q;
          p0_oe  = is_write;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= cfg_page ? p2_in : p0_in;
  end
endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic cfg_page,
  input logic cfg_wclk_en,
  input logic ale,
  input logic p0_oe,
  input logic p2_oe,
  input logic rd_n,
  input logic wr_n,
  input logic psen_n,
  input logic wclk,
  input logic done
);
  logic any_stb;
  assign any_stb = !(rd_n && wr_n && psen_n);

  assert_ale_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && psen_n));

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rd_n, ~wr_n, ~psen_n}) <= 1);

  assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(any_stb) && !any_stb));

  assert_ready_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_wclk_toggles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wclk_en && $past(cfg_wclk_en) && $past(rst_n)) |-> (wclk != $past(wclk)));

  assert_write_drives_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (cfg_page ? p2_oe : p0_oe));

  assert_read_floats_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> (cfg_page ? !p2_oe : !p0_oe));
endmodule

bind ebus_seq ebus_seq_chk u_chk (.*);

// File: tb/ebus_seq_bench.sv
module ebus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_strobe = '0;
  logic [1:0]  req_waits = '0;
  logic [7:0]  req_wdata = '0;
  logic        cfg_long_ale = 1'b0;
  logic        cfg_page = 1'b0;
  logic        cfg_rt_wait_en = 1'b0;
  logic        cfg_wclk_en = 1'b0;
  logic        await_n = 1'b1;
  logic        wait_n = 1'b1;
  logic [7:0]  p0_in = '0;
  logic [7:0]  p2_in = '0;
  logic        ale, p0_oe, p2_oe, rd_n, wr_n, psen_n, wclk, done;
  logic [7:0]  p0_out, p2_out, rdata;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ebus_seq u_ebus_seq (.*);

  typedef struct {
    int         ale_len;
    int         stb_len;
    logic [2:0] mask;
    logic [7:0] lo;
    logic [7:0] hi;
    logic       page;
    logic       write;
    logic [7:0] wdata;
    logic [7:0] rdata;
  } exp_t;

  exp_t q[$];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Monitor: measures each bus cycle and compares with the queued item.
  int ale_cnt = 0, stb_cnt = 0;
  logic [2:0] mask_seen = '0;
  logic done_prev = 1'b0, stb_prev = 1'b0;
  logic [7:0] a_p0, a_p2, s_addr, s_data;
  logic a_oe, s_addr_oe, s_data_oe;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_prev) chk(done == 1'b0, "R9 done one clock", done, 0);
      if (ale) begin
        if (ale_cnt == 0) begin a_p0 = p0_out; a_p2 = p2_out; a_oe = p0_oe & p2_oe; end
        ale_cnt++;
      end
      if (!(rd_n && wr_n && psen_n)) begin
        if (stb_cnt == 0) begin
          s_addr    = cfg_page ? p0_out : p2_out;
          s_addr_oe = cfg_page ? p0_oe : p2_oe;
          s_data    = cfg_page ? p2_out : p0_out;
          s_data_oe = cfg_page ? p2_oe : p0_oe;
        end
        stb_cnt++;
        mask_seen = mask_seen | {~psen_n, ~wr_n, ~rd_n};
      end
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(stb_prev && rd_n && wr_n && psen_n, "R9 done after strobe", stb_prev, 1);
          chk(ale_cnt == e.ale_len, "R2 ale width", ale_cnt, e.ale_len);
          chk(a_p0 == e.lo && a_p2 == e.hi && a_oe, "R2 ale address", {a_p2, a_p0}, {e.hi, e.lo});
          chk(stb_cnt == e.stb_len, "R5/R6/R7 strobe length", stb_cnt, e.stb_len);
          chk(mask_seen == e.mask, "R12 strobe select", mask_seen, e.mask);
          if (e.page)
            chk(s_addr == e.lo && s_addr_oe, "R4 page addr port", s_addr, e.lo);
          else
            chk(s_addr == e.hi && s_addr_oe, "R3 nonpage addr port", s_addr, e.hi);
          chk(s_data_oe == e.write, "R10 data enable", s_data_oe, e.write);
          if (e.write) chk(s_data == e.wdata, "R10 write data", s_data, e.wdata);
          else         chk(rdata == e.rdata, "R9 read data", rdata, e.rdata);
        end
        ale_cnt = 0; stb_cnt = 0; mask_seen = '0;
      end
      done_prev = done;
      stb_prev  = !(rd_n && wr_n && psen_n);
    end
  end

  // Driver: pushes the expected item, offers the request, applies wait stimulus.
  task automatic issue(input logic [15:0] addr, input logic [1:0] sel, input logic [1:0] ws,
                       input logic [7:0] wd, input logic long_a, input logic page,
                       input int stall_kind, input int d, input int exp_len);
    exp_t e;
    @(negedge clk);
    cfg_long_ale = long_a;
    cfg_page = page;
    p0_in = addr[7:0] ^ 8'h5A;
    p2_in = addr[15:8] ^ 8'hC3;
    if (stall_kind == 1) await_n = 1'b0;
    if (stall_kind == 2) begin wait_n = 1'b0; cfg_rt_wait_en = 1'b1; end
    if (stall_kind == 3) begin wait_n = 1'b0; cfg_rt_wait_en = 1'b0; end
    e.ale_len = long_a ? 3 : 1;
    e.stb_len = exp_len;
    e.mask    = (sel == 2'd1) ? 3'b010 : (sel == 2'd2) ? 3'b100 : 3'b001;
    e.lo      = addr[7:0];
    e.hi      = addr[15:8];
    e.page    = page;
    e.write   = (sel == 2'd1);
    e.wdata   = wd;
    e.rdata   = page ? (addr[15:8] ^ 8'hC3) : (addr[7:0] ^ 8'h5A);
    q.push_back(e);
    req_addr = addr; req_strobe = sel; req_waits = ws; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 ready low after accept", req_ready, 0);
    if (stall_kind == 1 || stall_kind == 2) begin
      while (rd_n && wr_n && psen_n) @(negedge clk);
      repeat (d) @(negedge clk);
      await_n = 1'b1;
      wait_n = 1'b1;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready back after done", req_ready, 1);
    wait_n = 1'b1;
    cfg_rt_wait_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk({ale, done, wclk, p0_oe, p2_oe} == 5'b0, "R1 idle outputs", {ale, done, wclk, p0_oe, p2_oe}, 0);
    chk({rd_n, wr_n, psen_n} == 3'b111, "R1 strobes", {rd_n, wr_n, psen_n}, 7);

    issue(16'hA53C, 2'd0, 2'd0, 8'h00, 1'b1, 1'b0, 0, 0, 2);  // R2 R3 R5 R9
    issue(16'h1234, 2'd1, 2'd1, 8'h9E, 1'b0, 1'b0, 0, 0, 4);  // R10 R12
    issue(16'hBEEF, 2'd2, 2'd3, 8'h00, 1'b1, 1'b1, 0, 0, 8);  // R4 R12 code
    issue(16'h7081, 2'd1, 2'd2, 8'h6B, 1'b0, 1'b1, 0, 0, 6);  // R4 R10 page write
    issue(16'h0F0F, 2'd0, 2'd0, 8'h00, 1'b1, 1'b0, 1, 5, 8);  // R6 async wait
    issue(16'hC001, 2'd0, 2'd0, 8'h00, 1'b0, 1'b1, 2, 4, 5);  // R7 real-time wait
    issue(16'h55AA, 2'd0, 2'd1, 8'h00, 1'b0, 1'b0, 3, 0, 4);  // R7 ignored when off
    issue(16'h3C3C, 2'd3, 2'd0, 8'h00, 1'b0, 1'b0, 0, 0, 2);  // R12 code 3 reads

    // R8 wait clock
    @(negedge clk);
    cfg_wclk_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      logic prev;
      prev = wclk;
      @(negedge clk);
      chk(wclk != prev, "R8 wclk toggles", wclk, !prev);
    end
    cfg_wclk_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(wclk == 1'b0, "R8 wclk held low", wclk, 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule